// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block picks which of five interrupt sources is serviced next by a small processor core. The sources are two external request pins, two timer overflow pulses and one serial request, which is the OR of a transmit-done and a receive-done level. Each source has its own enable, a global enable masks them all, and one bit per source places it at the high or the low level. Each external pin can be set to latch falling edges or to follow a low level.

Source flags are latched at the end of every machine cycle, marked by `cycle_end_i`. The latched set is polled at the end of the next machine cycle. When a source wins and nothing blocks the call, the block raises `call_req_o` together with a 16-bit vector address. It holds both until the core answers with `call_ack_i`. The acknowledge marks that level as in service. A return pulse on `reti_i` ends the higher of the levels in service. This allows one low-level service to be interrupted by one high-level service. Stack pushing and instruction execution stay outside the block and are seen only through these handshake inputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial. Within one level the lowest index wins. The vector is 0x0003 + 8*index, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R2: A source takes part only when its bit of `src_en_i` (bit = source index) and `glb_en_i` are both 1. A masked flag stays pending and is served once its enable is restored.
- R3: `prio_hi_i[index]` = 1 puts a source at the high level. When high and low requests are polled together, the high request wins regardless of index.
- R4: Flags are latched on the clock edge where `cycle_end_i` = 1. A flag set during machine cycle k is polled at the end of cycle k+1. `call_req_o` is therefore high after the second strobe edge that follows the flag, and not after the first.
- R5: Once raised, `call_req_o` and `vec_o` stay unchanged until `call_ack_i`. `call_req_o` falls on the edge that takes the acknowledge.
- R6: A new call is raised only on a strobe edge where `last_cyc_i` = 1, `reti_i` = 0 and `cfg_wr_i` = 0, and only while no call is pending.
- R7: An acknowledge marks the winner's level as in service. While low is in service, only high requests may call. While high is in service, no request may call. `reti_i` clears high if it is set, and otherwise clears low.
- R8: With `ext_edge_i[k]` = 1, a high-to-low change on `ext_n_i[k]` sets a flag. Vectoring to that source clears the flag. A new falling edge on the same edge as the acknowledge is kept. With `ext_edge_i[k]` = 0, the request follows a low pin and is never cleared by the block.
- R9: A one-cycle pulse on `tmr_ovf_i[k]` sets the flag of timer k. Vectoring to that timer clears the flag.
- R10: The serial request is `ser_tx_i | ser_rx_i` and is not cleared by vectoring. It calls again after its service ends if either input is still high.
- R11: After reset, `call_req_o` = 0, `vec_o` = 0, no level is in service and no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_end_i | input | 1 | Last clock of a machine cycle |
| last_cyc_i | input | 1 | Current machine cycle ends an instruction |
| ext_n_i | input | 2 | External request pins, active low |
| ext_edge_i | input | 2 | 1 = falling-edge mode, 0 = low-level mode |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_tx_i | input | 1 | Serial transmit-done level |
| ser_rx_i | input | 1 | Serial receive-done level |
| src_en_i | input | 5 | Per-source enables, indexed by source |
| glb_en_i | input | 1 | Global enable |
| prio_hi_i | input | 5 | Per-source high-level select |
| call_ack_i | input | 1 | Core has taken the pending call |
| reti_i | input | 1 | Return-from-interrupt executes this cycle |
| cfg_wr_i | input | 1 | Instruction writes the enable or priority setting |
| call_req_o | output | 1 | Call request |
| vec_o | output | 16 | Vector address of the pending call |

## Verification
Two functions can act on the same flag in the same clock. The acknowledge clears an edge-latched flag, and a new falling edge on the same pin sets it. The bench drives the pin low on exactly the edge that takes the acknowledge. It then ends the service and expects a second call to the same vector, because a set on that edge must win over the clear. A behavioural model compared on every clock checks the related cases in the same way: a return that coincides with a strobe must block that strobe's call and still free the level.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} irq_lvl_e;
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int NPAIR = 2,
  localparam int NSRC = 2*NPAIR + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_end_i,
  input  logic [NPAIR-1:0] ext_n_i,
  input  logic [NPAIR-1:0] ext_edge_i,
  input  logic [NPAIR-1:0] tmr_ovf_i,
  input  logic             ser_i,
  input  logic [NSRC-1:0]  clr_i,
  output logic [NSRC-1:0]  smp_o
);
  logic [NPAIR-1:0] prev_q, ext_f_q, tmr_f_q;
  logic [NSRC-1:0]  cur, clr_m;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic fall;
    assign fall = prev_q[k] & ~ext_n_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[k]  <= 1'b1;
        ext_f_q[k] <= 1'b0;
        tmr_f_q[k] <= 1'b0;
      end else begin
        prev_q[k]  <= ext_n_i[k];
        ext_f_q[k] <= ext_edge_i[k] ? ((ext_f_q[k] & ~clr_i[2*k]) | fall) : ~ext_n_i[k];
        tmr_f_q[k] <= (tmr_f_q[k] & ~clr_i[2*k+1]) | tmr_ovf_i[k];
      end
    end

    assign cur[2*k]     = ext_f_q[k];
    assign cur[2*k+1]   = tmr_f_q[k];
    assign clr_m[2*k]   = clr_i[2*k] & ext_edge_i[k];
    assign clr_m[2*k+1] = clr_i[2*k+1];

    // R8: a falling edge in edge mode is latched
    a_r8_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ext_edge_i[k] && prev_q[k] && !ext_n_i[k]) |=> ext_f_q[k]);
    // R8: level mode follows the pin
    a_r8_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_edge_i[k] && !ext_n_i[k]) |=> ext_f_q[k]);
    // R9: overflow pulse sets the timer flag
    a_r9_tmr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_ovf_i[k] |=> tmr_f_q[k]);
  end

  assign cur[NSRC-1]   = ser_i;
  assign clr_m[NSRC-1] = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          smp_o <= '0;
    else if (cycle_end_i) smp_o <= cur & ~clr_m;
    else                  smp_o <= smp_o & ~clr_m;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 5,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] smp_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            glb_en_i,
  input  logic [NSRC-1:0] hi_i,
  input  logic            ip_hi_i,
  input  logic            ip_lo_i,
  output logic            vld_o,
  output logic [IW-1:0]   idx_o,
  output irq_lvl_e        lvl_o
);
  logic [NSRC-1:0] act, req_hi, req_lo;
  logic [IW-1:0]   idx_hi, idx_lo;
  logic            any_hi, any_lo, ok_hi, ok_lo;

  assign act    = smp_i & en_i & {NSRC{glb_en_i}};
  assign req_hi = act & hi_i;
  assign req_lo = act & ~hi_i;
  assign ok_hi  = !ip_hi_i;
  assign ok_lo  = !ip_hi_i && !ip_lo_i;

  // fixed poll order: the lowest index wins, so scan downwards
  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    any_hi = 1'b0;
    any_lo = 1'b0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (req_hi[i]) begin idx_hi = IW'(i); any_hi = 1'b1; end
      if (req_lo[i]) begin idx_lo = IW'(i); any_lo = 1'b1; end
    end
  end

  always_comb begin
    vld_o = 1'b0;
    idx_o = idx_lo;
    lvl_o = LVL_LO;
    if (ok_hi && any_hi) begin
      vld_o = 1'b1;
      idx_o = idx_hi;
      lvl_o = LVL_HI;
    end else if (ok_lo && any_lo) begin
      vld_o = 1'b1;
    end
  end

  // R7: nothing may win while the high level is in service
  a_r7_hi_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_hi_i |-> !vld_o);
  // R3: a polled high request is never passed over for a low one
  a_r3_hi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && lvl_o == LVL_LO) |-> ((smp_i & en_i & hi_i) == '0 || !glb_en_i));
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_prio_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_i,
  input  irq_lvl_e set_lvl_i,
  input  logic     reti_i,
  output logic     ip_hi_o,
  output logic     ip_lo_o
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = ip_hi_o;
    lo_d = ip_lo_o;
    if (reti_i) begin
      if (ip_hi_o) hi_d = 1'b0;
      else         lo_d = 1'b0;
    end
    if (set_i) begin
      if (set_lvl_i == LVL_HI) hi_d = 1'b1;
      else                     lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_hi_o <= 1'b0;
      ip_lo_o <= 1'b0;
    end else begin
      ip_hi_o <= hi_d;
      ip_lo_o <= lo_d;
    end
  end

  // R7: a low service cannot begin under a high one
  a_r7_no_lo_under_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_hi_o |=> !$rose(ip_lo_o));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NPAIR    = 2,
  parameter int AW       = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8,
  localparam int NSRC = 2*NPAIR + 1,
  localparam int IW   = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_end_i,
  input  logic             last_cyc_i,
  input  logic [NPAIR-1:0] ext_n_i,
  input  logic [NPAIR-1:0] ext_edge_i,
  input  logic [NPAIR-1:0] tmr_ovf_i,
  input  logic             ser_tx_i,
  input  logic             ser_rx_i,
  input  logic [NSRC-1:0]  src_en_i,
  input  logic             glb_en_i,
  input  logic [NSRC-1:0]  prio_hi_i,
  input  logic             call_ack_i,
  input  logic             reti_i,
  input  logic             cfg_wr_i,
  output logic             call_req_o,
  output logic [AW-1:0]    vec_o
);
  logic [NSRC-1:0] smp, clr;
  logic            vld, ack, issue, ip_hi, ip_lo;
  logic [IW-1:0]   idx, src_q;
  irq_lvl_e        lvl, lvl_q;

  assign ack = call_ack_i & call_req_o;
  assign clr = ack ? (NSRC'(1) << src_q) : '0;

  irq_src_flags #(.NPAIR(NPAIR)) u_flags (
    .clk_i, .rst_ni, .cycle_end_i, .ext_n_i, .ext_edge_i, .tmr_ovf_i,
    .ser_i(ser_tx_i | ser_rx_i), .clr_i(clr), .smp_o(smp)
  );

  irq_pick #(.NSRC(NSRC)) u_pick (
    .clk_i, .rst_ni, .smp_i(smp), .en_i(src_en_i), .glb_en_i, .hi_i(prio_hi_i),
    .ip_hi_i(ip_hi), .ip_lo_i(ip_lo), .vld_o(vld), .idx_o(idx), .lvl_o(lvl)
  );

  irq_nest u_nest (
    .clk_i, .rst_ni, .set_i(ack), .set_lvl_i(lvl_q), .reti_i,
    .ip_hi_o(ip_hi), .ip_lo_o(ip_lo)
  );

  assign issue = cycle_end_i && !call_req_o && last_cyc_i && !reti_i && !cfg_wr_i && vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_req_o <= 1'b0;
      vec_o      <= '0;
      src_q      <= '0;
      lvl_q      <= LVL_LO;
    end else if (issue) begin
      call_req_o <= 1'b1;
      vec_o      <= AW'(VEC_BASE) + AW'(VEC_STEP) * AW'(idx);
      src_q      <= idx;
      lvl_q      <= lvl;
    end else if (ack) begin
      call_req_o <= 1'b0;
    end
  end

  // R5: request and vector hold until acknowledged
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_req_o && !call_ack_i) |=> (call_req_o && $stable(vec_o)));
  // R6: calls start only at an unblocked instruction boundary
  a_r6_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(call_req_o) |-> $past(cycle_end_i && last_cyc_i && !reti_i && !cfg_wr_i));
  // R1: vector lies on the step grid
  a_r1_vec_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_req_o |-> ((vec_o - AW'(VEC_BASE)) % AW'(VEC_STEP)) == '0);
  // R7: no call starts while high is in service
  a_r7_no_call_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(call_req_o) |-> !$past(ip_hi));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic last_cyc = 1'b1, ser_tx = 1'b0, ser_rx = 1'b0, glb_en = 1'b1;
  logic call_ack = 1'b0, reti = 1'b0, cfg_wr = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_edge = 2'b11, tmr_ovf = 2'b00;
  logic [4:0] src_en = 5'h1f, prio_hi = 5'h00;
  logic call_req;
  logic [15:0] vec;
  logic cycle_end;
  int mc = 0, nchk = 0, nbad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mc <= 0; else mc <= (mc == 3) ? 0 : mc + 1;
  assign cycle_end = (mc == 3);

  irq_prio_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cycle_end_i(cycle_end), .last_cyc_i(last_cyc),
    .ext_n_i(ext_n), .ext_edge_i(ext_edge), .tmr_ovf_i(tmr_ovf),
    .ser_tx_i(ser_tx), .ser_rx_i(ser_rx), .src_en_i(src_en), .glb_en_i(glb_en),
    .prio_hi_i(prio_hi), .call_ack_i(call_ack), .reti_i(reti), .cfg_wr_i(cfg_wr),
    .call_req_o(call_req), .vec_o(vec)
  );

  // behavioural reference
  bit m_req, m_lvl, m_iph, m_ipl;
  int m_src;
  logic [15:0] m_vec;
  bit [4:0] m_smp;
  bit [1:0] m_ef, m_tf, m_prev;

  always @(posedge clk or negedge rst_n) begin : model
    int w;
    bit wl, ack, issue;
    bit [4:0] cur, clr;
    if (!rst_n) begin
      m_req = 0; m_lvl = 0; m_iph = 0; m_ipl = 0; m_src = 0; m_vec = 0;
      m_smp = 0; m_ef = 0; m_tf = 0; m_prev = 2'b11;
    end else begin
      w = -1; wl = 0;
      if (!m_iph)
        for (int i = 0; i < 5; i++)
          if (w < 0 && m_smp[i] && src_en[i] && glb_en && prio_hi[i]) begin w = i; wl = 1; end
      if (w < 0 && !m_iph && !m_ipl)
        for (int i = 0; i < 5; i++)
          if (w < 0 && m_smp[i] && src_en[i] && glb_en && !prio_hi[i]) w = i;
      ack = call_ack && m_req;
      issue = cycle_end && !m_req && last_cyc && !reti && !cfg_wr && (w >= 0);
      clr = 0;
      if (ack) begin
        if (m_src == 4) clr = 0;
        else if (m_src % 2 == 1) clr[m_src] = 1;
        else if (ext_edge[m_src/2]) clr[m_src] = 1;
      end
      cur = {ser_tx | ser_rx, m_tf[1], m_ef[1], m_tf[0], m_ef[0]};
      m_smp = cycle_end ? (cur & ~clr) : (m_smp & ~clr);
      for (int k = 0; k < 2; k++) begin
        if (ext_edge[k]) m_ef[k] = (m_ef[k] && !(ack && m_src == 2*k)) || (m_prev[k] && !ext_n[k]);
        else             m_ef[k] = !ext_n[k];
        m_tf[k] = (m_tf[k] && !(ack && m_src == 2*k+1)) || tmr_ovf[k];
      end
      m_prev = ext_n;
      if (reti) begin if (m_iph) m_iph = 0; else m_ipl = 0; end
      if (ack) begin if (m_lvl) m_iph = 1; else m_ipl = 1; m_req = 0; end
      if (issue) begin m_req = 1; m_vec = 16'(3 + 8*w); m_src = w; m_lvl = wl; end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && !done)
      chk(call_req === m_req && (!m_req || vec === m_vec), "R5 model compare",
          {15'd0, call_req, vec}, {15'd0, m_req, m_vec});

  task automatic to_strobe();
    do @(negedge clk); while (!cycle_end);
  endtask

  task automatic wait_call(logic [15:0] exp, string tag);
    for (int n = 0; n < 80 && !call_req; n++) @(negedge clk);
    chk(call_req && vec == exp, tag, {15'd0, call_req, vec}, {16'd1, exp});
  endtask

  task automatic no_call(int n, string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (call_req) seen = 1; end
    chk(!seen, tag, {31'd0, seen}, 0);
  endtask

  task automatic do_ack();
    call_ack = 1; @(negedge clk); call_ack = 0;
  endtask

  task automatic do_reti();
    to_strobe(); reti = 1; @(negedge clk); reti = 0;
  endtask

  task automatic tmr_pulse(int k);
    @(negedge clk); tmr_ovf[k] = 1; @(negedge clk); tmr_ovf[k] = 0;
  endtask

  task automatic ext_fall(int k);
    @(negedge clk); ext_n[k] = 0; @(negedge clk); ext_n[k] = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(call_req == 0 && vec == 0, "R11 reset state", {15'd0, call_req, vec}, 0);
    rst_n = 1;
    no_call(12, "R11 idle after reset");

    // single timer
    tmr_pulse(1);
    wait_call(16'h001B, "R9 timer1 vector"); do_ack(); do_reti();

    // three low requests together
    @(negedge clk); tmr_ovf[0] = 1; ext_n[1] = 0; ser_tx = 1;
    @(negedge clk); tmr_ovf[0] = 0; ext_n[1] = 1;
    wait_call(16'h000B, "R1 timer0 first"); do_ack(); do_reti();
    wait_call(16'h0013, "R1 ext1 second"); do_ack(); do_reti();
    wait_call(16'h0023, "R1 serial third"); do_ack(); do_reti();
    wait_call(16'h0023, "R10 serial not cleared"); do_ack();
    ser_tx = 0; do_reti();
    no_call(16, "R10 serial quiet once cleared");

    // high beats low
    prio_hi = 5'b10000;
    @(negedge clk); tmr_ovf[0] = 1; ser_rx = 1;
    @(negedge clk); tmr_ovf[0] = 0;
    wait_call(16'h0023, "R3 high serial beats timer0"); do_ack();
    no_call(16, "R7 high in service blocks low");
    ser_rx = 0; do_reti();
    wait_call(16'h000B, "R7 low after high return"); do_ack(); do_reti();
    prio_hi = 0;

    // enables
    src_en[3] = 0; tmr_pulse(1);
    no_call(20, "R2 source masked");
    src_en[3] = 1;
    wait_call(16'h001B, "R2 pending after unmask"); do_ack(); do_reti();
    glb_en = 0; ext_fall(0);
    no_call(20, "R2 global mask");
    glb_en = 1;
    wait_call(16'h0003, "R2 after global enable"); do_ack(); do_reti();

    // nesting
    tmr_pulse(0);
    wait_call(16'h000B, "R7 low service"); do_ack();
    ext_fall(0);
    no_call(20, "R7 low cannot preempt low");
    prio_hi[3] = 1; tmr_pulse(1);
    wait_call(16'h001B, "R7 high preempts low"); do_ack();
    do_reti();
    no_call(16, "R7 low still in service");
    do_reti();
    wait_call(16'h0003, "R7 ext0 after both returns"); do_ack(); do_reti();
    prio_hi = 0;

    // blocking conditions
    last_cyc = 0; tmr_pulse(1);
    no_call(20, "R6 not last cycle");
    last_cyc = 1;
    wait_call(16'h001B, "R6 at instruction end"); do_ack(); do_reti();
    cfg_wr = 1; tmr_pulse(0);
    no_call(20, "R6 config write blocks");
    cfg_wr = 0;
    wait_call(16'h000B, "R6 after config write"); do_ack(); do_reti();
    @(negedge clk); reti = 1; tmr_pulse(1);
    no_call(20, "R6 return blocks");
    reti = 0;
    wait_call(16'h001B, "R6 after return"); do_ack(); do_reti();

    // level mode
    ext_edge[0] = 0; @(negedge clk); ext_n[0] = 0;
    wait_call(16'h0003, "R8 level request"); do_ack(); do_reti();
    wait_call(16'h0003, "R8 level not cleared"); do_ack();
    ext_n[0] = 1; do_reti();
    no_call(16, "R8 level released");
    ext_edge[0] = 1;

    // sampling latency and hold
    to_strobe(); @(negedge clk); tmr_ovf[0] = 1; @(negedge clk); tmr_ovf[0] = 0;
    to_strobe(); @(negedge clk);
    chk(!call_req, "R4 not after first strobe", {31'd0, call_req}, 0);
    to_strobe(); @(negedge clk);
    chk(call_req && vec == 16'h000B, "R4 after second strobe", {15'd0, call_req, vec}, {16'd1, 16'h000B});
    repeat (12) @(negedge clk);
    chk(call_req && vec == 16'h000B, "R5 held without ack", {15'd0, call_req, vec}, {16'd1, 16'h000B});
    do_ack();
    chk(!call_req, "R5 drops on ack", {31'd0, call_req}, 0);
    do_reti();

    // acknowledge and new edge on the same clock
    ext_fall(0);
    wait_call(16'h0003, "R8 edge request");
    ext_n[0] = 0; call_ack = 1; @(negedge clk); call_ack = 0; ext_n[0] = 1;
    no_call(12, "R8 served edge held off");
    do_reti();
    wait_call(16'h0003, "R8 edge on ack kept"); do_ack(); do_reti();
    no_call(16, "R8 edge flag cleared");

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule